// File: doc/BRIEF.md
# Byte Prefetch Queue with Fetch Counter

This block sits between a processor core and an on-chip bus and keeps a small queue of upcoming code bytes ready for the core. A fetch counter holds the address of the byte now at the head of the queue. Each time the core takes that byte, the counter steps by one. A separate fetch address walks ahead of it and issues single-byte bus reads whenever the queue has room. A taken branch or jump loads a new target into both addresses, empties the queue, and discards any bus read still in flight.

The head only advances when the core asks for a byte and is actually running. If the queue were allowed to move while the core is halted, the counter would end up one byte ahead of the core's program counter. That gating is the central property of this block. A registered diagnostic output flags any such advance. Bus activity can be parked with a stop request. The grant follows once any read in progress has completed, and it drops again after the request is withdrawn.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is held, `head_valid`, `bus_strobe`, `stop_grant` and `adv_while_halted` are 0 and `fetch_ctr` is 0.
- R2: A bus read starts only when fewer than DEPTH (default 4) bytes are held and no read is outstanding. `bus_addr` stays stable while `bus_strobe` is high until `bus_ready`. The read returns one byte, and reads run over consecutive addresses.
- R3: With `insn_req`, `cpu_run` and `head_valid` all high at a clock edge, the head byte is removed, `fetch_ctr` rises by one, and the new head is the byte read from the new `fetch_ctr`.
- R4: With `insn_req` low, `fetch_ctr` and `head_byte` keep their values.
- R5: With `cpu_run` low, `fetch_ctr` and `head_byte` keep their values even when `insn_req` is high.
- R6: `branch_load` at an edge sets `fetch_ctr` to `branch_addr` and clears `head_valid`. Later reads start at `branch_addr`.
- R7: A read outstanding when `branch_load` arrives keeps its `bus_addr` until `bus_ready`. Its byte is discarded and never appears at the head.
- R8: While `stop_req` or `stop_grant` is high, no new read starts. `stop_grant` rises one edge after `stop_req` when no read is outstanding. Otherwise it rises at the edge where `bus_ready` completes the read.
- R9: `stop_grant` falls one edge after `stop_req` is removed, and fetching resumes at the edge after that.
- R10: `adv_while_halted` goes high the edge after any cycle in which `fetch_ctr` changed without a branch while `cpu_run` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_req | input | 1 | Core asks for the head byte |
| cpu_run | input | 1 | Core is running (not halted) |
| branch_load | input | 1 | Taken branch: reload and flush |
| branch_addr | input | AW | Branch target address |
| stop_req | input | 1 | Request to park bus activity |
| bus_rdata | input | 8 | Read data from the bus |
| bus_ready | input | 1 | Read data valid, read completes |
| head_byte | output | 8 | Byte at the queue head |
| head_valid | output | 1 | Queue holds at least one byte |
| fetch_ctr | output | AW | Address of the head byte |
| bus_addr | output | AW | Address of the outstanding read |
| bus_strobe | output | 1 | A read is outstanding |
| stop_grant | output | 1 | Bus activity is parked |
| adv_while_halted | output | 1 | Counter moved while core halted |

## Verification
The main consume path is driven by a cycle table that mixes requests with the core running, requests while halted, and idle cycles. A refill with a ready bus runs alongside it. This separates the request gating from the run gating, and it checks that the head byte always matches the memory byte at `fetch_ctr`. Branches are tried into an idle queue and over a read that is still outstanding, so a flush can be told apart from a dropped late byte. Stop requests are issued with the bus idle and with a read pending, which shows whether the grant waits for completion.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_req,
  input  logic          cpu_run,
  input  logic          branch_load,
  input  logic [AW-1:0] branch_addr,
  input  logic          stop_req,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_ready,
  output logic [7:0]    head_byte,
  output logic          head_valid,
  output logic [AW-1:0] fetch_ctr,
  output logic [AW-1:0] bus_addr,
  output logic          bus_strobe,
  output logic          stop_grant,
  output logic          adv_while_halted
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    q [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [AW-1:0] faddr, ctr_nx;
  logic          busy, drop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire consume = insn_req & cpu_run & head_valid & ~branch_load;
  wire land    = busy & bus_ready & ~drop & ~branch_load;
  wire start   = ~busy & ~branch_load & ~stop_req & ~stop_grant
               & (count < CW'(DEPTH));

  assign head_valid = (count != '0);
  assign head_byte  = q[rd_ptr];
  assign bus_strobe = busy;
  assign ctr_nx     = branch_load ? branch_addr
                    : consume     ? fetch_ctr + 1'b1 : fetch_ctr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0; wr_ptr <= '0; count <= '0;
      fetch_ctr <= '0; faddr <= '0; bus_addr <= '0;
      busy <= 1'b0; drop <= 1'b0; stop_grant <= 1'b0;
      adv_while_halted <= 1'b0;
    end else begin
      fetch_ctr  <= ctr_nx;
      stop_grant <= stop_req & ~(busy & ~bus_ready);
      adv_while_halted <= ~cpu_run & ~branch_load & (ctr_nx != fetch_ctr);
      if (busy && bus_ready) begin
        busy <= 1'b0; drop <= 1'b0;
      end else if (start) begin
        busy <= 1'b1; bus_addr <= faddr; faddr <= faddr + 1'b1;
      end
      if (branch_load) begin
        faddr <= branch_addr;
        rd_ptr <= '0; wr_ptr <= '0; count <= '0;
        drop <= busy & ~bus_ready;
      end else begin
        if (land) wr_ptr <= bump(wr_ptr);
        if (consume) rd_ptr <= bump(rd_ptr);
        count <= count + CW'(land) - CW'(consume);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (land) q[wr_ptr] <= bus_rdata;
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && !bus_ready |=> bus_strobe && $stable(bus_addr)); // R2
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_strobe) |-> $past(count) < CW'(DEPTH)); // R2
  AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_req && !branch_load |=> $stable(fetch_ctr)); // R4
  AST_HOLD_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_run && !branch_load |=> $stable(fetch_ctr)); // R5
  AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    branch_load |=> fetch_ctr == $past(branch_addr) && !head_valid); // R6
  AST_NO_FETCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req || stop_grant) && !bus_strobe |=> !bus_strobe); // R8
  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant |-> !bus_strobe); // R8
  AST_NO_HALTED_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_while_halted); // R10
endmodule

// File: tb/test_prefetch_queue.sv
`timescale 1ns/1ps
module test_prefetch_queue;
  localparam int AW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic insn_req = 0, cpu_run = 1, branch_load = 0, stop_req = 0, bus_ready = 1;
  logic [AW-1:0] branch_addr = '0;
  logic [7:0] bus_rdata, head_byte;
  logic head_valid, bus_strobe, stop_grant, adv_while_halted;
  logic [AW-1:0] fetch_ctr, bus_addr;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign bus_rdata = mem(bus_addr);

  prefetch_queue #(.AW(AW), .DEPTH(4)) i_prefetch_queue (
    .clk(clk), .rst_n(rst_n), .insn_req(insn_req), .cpu_run(cpu_run),
    .branch_load(branch_load), .branch_addr(branch_addr), .stop_req(stop_req),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .head_byte(head_byte),
    .head_valid(head_valid), .fetch_ctr(fetch_ctr), .bus_addr(bus_addr),
    .bus_strobe(bus_strobe), .stop_grant(stop_grant),
    .adv_while_halted(adv_while_halted));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // bits {insn_req, cpu_run}
  localparam logic [1:0] VEC [12] = '{2'b11, 2'b11, 2'b10, 2'b01, 2'b11, 2'b10,
                                      2'b00, 2'b11, 2'b11, 2'b11, 2'b10, 2'b11};

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [AW-1:0] exp_ctr;
    step(3);
    chk(!head_valid && !bus_strobe && !stop_grant && !adv_while_halted, "R1",
        {head_valid, bus_strobe, stop_grant, adv_while_halted}, 0);
    chk(fetch_ctr == 0, "R1", fetch_ctr, 0);
    @(negedge clk); rst_n = 1;
    step(12);
    chk(head_valid && head_byte == mem(0), "R2", head_byte, mem(0));
    chk(!bus_strobe, "R2 full queue", bus_strobe, 0);
    chk(fetch_ctr == 0, "R4", fetch_ctr, 0);

    exp_ctr = 0;
    foreach (VEC[i]) begin
      logic pre_v;
      @(negedge clk);
      {insn_req, cpu_run} = VEC[i];
      pre_v = head_valid;
      if (insn_req && cpu_run && pre_v) exp_ctr++;
      @(posedge clk); #1;
      chk(fetch_ctr == exp_ctr, !cpu_run ? "R5" : insn_req ? "R3" : "R4",
          fetch_ctr, exp_ctr);
      if (head_valid) chk(head_byte == mem(fetch_ctr), "R3 head", head_byte, mem(fetch_ctr));
      chk(!adv_while_halted, "R10", adv_while_halted, 0);
    end
    @(negedge clk); insn_req = 0; cpu_run = 1;

    @(negedge clk); branch_load = 1; branch_addr = 16'h1230;
    step(1);
    chk(fetch_ctr == 16'h1230 && !head_valid, "R6", fetch_ctr, 16'h1230);
    @(negedge clk); branch_load = 0;
    step(10);
    chk(head_valid && head_byte == mem(16'h1230), "R6 target", head_byte, mem(16'h1230));

    @(negedge clk); bus_ready = 0; branch_load = 1; branch_addr = 16'h2000;
    step(1);
    @(negedge clk); branch_load = 0;
    step(1);
    chk(bus_strobe && bus_addr == 16'h2000, "R2 addr", bus_addr, 16'h2000);
    @(negedge clk); branch_load = 1; branch_addr = 16'h3000;
    step(1);
    chk(bus_strobe && bus_addr == 16'h2000, "R7 hold", bus_addr, 16'h2000);
    chk(fetch_ctr == 16'h3000, "R6", fetch_ctr, 16'h3000);
    @(negedge clk); branch_load = 0; bus_ready = 1;
    step(1);
    chk(!head_valid, "R7 drop", head_valid, 0);
    step(10);
    chk(head_valid && head_byte == mem(16'h3000), "R7 target", head_byte, mem(16'h3000));

    @(negedge clk); stop_req = 1;
    step(1);
    chk(stop_grant && !bus_strobe, "R8 idle grant", stop_grant, 1);
    @(negedge clk); stop_req = 0;
    step(1);
    chk(!stop_grant, "R9", stop_grant, 0);
    @(negedge clk); bus_ready = 0; insn_req = 1;
    step(1);
    chk(fetch_ctr == 16'h3001, "R3", fetch_ctr, 16'h3001);
    @(negedge clk); insn_req = 0;
    step(1);
    chk(bus_strobe, "R2 refill", bus_strobe, 1);
    @(negedge clk); stop_req = 1;
    step(2);
    chk(!stop_grant, "R8 wait", stop_grant, 0);
    @(negedge clk); bus_ready = 1;
    step(1);
    chk(stop_grant && !bus_strobe, "R8 grant", stop_grant, 1);
    @(negedge clk); insn_req = 1;
    step(1);
    @(negedge clk); insn_req = 0;
    step(3);
    chk(!bus_strobe, "R8 parked", bus_strobe, 0);
    @(negedge clk); stop_req = 0;
    step(1);
    chk(!stop_grant && !bus_strobe, "R9 drop", stop_grant, 0);
    step(1);
    chk(bus_strobe, "R9 resume", bus_strobe, 1);
    chk(!adv_while_halted, "R10", adv_while_halted, 0);
    finish_run();
  end
endmodule